// File: doc/BRIEF.md
# Free-Running Timer with Compare and Capture Channels

This block provides one 16-bit up counter that all of its channels share. Eight compare channels each hold a 16-bit match value. When the counter steps onto that value, the channel inverts its output pin and latches a sticky flag. Four capture channels each watch an external pin. When a pin shows the selected edge, the channel copies the counter into its capture register and latches a sticky flag. Each flag can drive an interrupt line when its enable bit is set. One timebase therefore serves independent waveform generation and pulse-width or period measurement.

Software programs the block through a simple word-wide register bus. A write takes effect on the clock edge where `bus_wr` is high. Read data depends on `bus_addr` alone, with no extra cycle. The control word has these bits:

- bit 0: halts the count.
- bit 1: zeroes the count when written as 1.
- bit 2: makes compare channel 0 define the counter period.
- bits 5:4: select a prescale of 1, 2, 4 or 8 clocks per count step.

The count register can be loaded while the counter is halted. Capture pins are synchronised inside the block, so a capture pulse must stay at one level for at least four clocks.

Top module: `frt_cc_top`

Register addresses: 0 control, 1 count, 2 compare interrupt enables, 3 compare flags, 4 capture configuration, 5 capture flags, 6 compare pin levels, 8 to 15 compare values of channels 0 to 7, 16 to 19 capture values of channels 0 to 3. Capture configuration layout: bits [2i+1:2i] hold the edge select of channel i (00 off, 01 rising, 10 falling, 11 both), and bit 8+i enables the interrupt of channel i.

## Requirements
- R1: After reset the count starts from 0 and runs. The control word reads 0. All flags, compare pins and interrupt lines are 0.
- R2: The count advances by one every 2^n clocks, where n is control bits [5:4]. Any control write restarts the prescaler, so at n=3 the first step lands 8 clocks after the write.
- R3: While control bit 0 is 1, the count holds. A write to address 1 loads the count only while it is halted and is ignored while it runs.
- R4: Writing 1 to control bit 1 sets the count and the prescaler to 0. The bit always reads back as 0.
- R5: When the count steps onto a channel's compare value, that channel's pin (address 6, bit i) inverts and its flag (address 3, bit i) sets. The interrupt line of compare channel i equals its flag ANDed with enable bit i at address 2.
- R6: With control bit 2 set, the count returns to 0 on the step after it equals the compare value of channel 0, so it never exceeds that value.
- R7: A capture channel copies the count into its capture register, and sets flag bit i at address 5, only on the edge its configuration selects. When the select is 00 it never captures.
- R8: Flags are sticky. Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. A flag that sets in the same cycle as a clearing write ends up set.
- R9: The interrupt line of capture channel i equals its flag ANDed with configuration bit 8+i.
- R10: The count wraps from 0xFFFF to 0x0000, and a compare value of 0 matches on that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| cap_in | input | 4 | Capture input pins |
| cmp_out | output | 8 | Compare output pins |
| cmp_irq | output | 8 | Compare interrupt lines |
| cap_irq | output | 4 | Capture interrupt lines |

## Verification
A capture edge can be detected in the same clock in which software writes 0 to the capture flag register. The bench makes this collision happen on purpose. It changes the pin exactly two clocks before the edge where the two-stage synchroniser reports the edge, and it times the clearing write to be sampled on that same edge. The flag is expected to read back as set, the capture register to hold the preset count, and the interrupt line to be high. A later write of 0 with no edge present must then clear the flag.

// File: rtl/frt_pkg.sv
// Shared constants for the free-running timer block: register addresses,
// control bit positions and the capture edge-select encoding.
package frt_pkg;
    localparam int CNT_W        = 16;
    localparam int BUS_W        = 16;
    localparam int ADR_W        = 5;
    localparam int SEL_W        = 2;

    localparam int ADR_CTRL     = 0;
    localparam int ADR_COUNT    = 1;
    localparam int ADR_CMP_IE   = 2;
    localparam int ADR_CMP_FLAG = 3;
    localparam int ADR_CAP_CFG  = 4;
    localparam int ADR_CAP_FLAG = 5;
    localparam int ADR_PINS     = 6;
    localparam int ADR_CMP_BASE = 8;
    localparam int ADR_CAP_BASE = 16;

    localparam int CTRL_HALT    = 0;
    localparam int CTRL_ZERO    = 1;
    localparam int CTRL_M0WRAP  = 2;
    localparam int CTRL_PS_LO   = 4;
    localparam int CAP_IE_LO    = 8;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;
endpackage

// File: rtl/frt_timebase.sv
// Prescaler and 16-bit up counter.
// The counter steps once per prescaled tick while running. It is zeroed by
// a clear request, and it can wrap to 0 after matching channel 0's value.
// Assumes clr_req and ps_restart are single-cycle strobes from the register
// block. step is high for the one cycle after the count was moved by a tick.
module frt_timebase #(
    parameter int CNT_W = 16,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             clr_req,
    input  logic             ps_restart,
    input  logic [SEL_W-1:0] ps_sel,
    input  logic             preset_we,
    input  logic [CNT_W-1:0] preset_val,
    input  logic             m0_wrap_en,
    input  logic [CNT_W-1:0] m0_val,
    output logic [CNT_W-1:0] count,
    output logic             step
);
    localparam int PS_W = (1 << SEL_W) - 1;

    logic [PS_W-1:0] ps_q;
    logic [PS_W:0]   ps_one;
    logic [PS_W-1:0] ps_mask;
    logic [CNT_W-1:0] cnt_q;
    logic            tick;
    logic            wrap0;

    // Prescale mask: the low ps_sel bits of the prescaler must all be set
    always_comb begin
        ps_one  = (PS_W+1)'(1) << ps_sel;
        ps_mask = PS_W'(ps_one - (PS_W+1)'(1));
    end

    // Tick and wrap conditions for this cycle
    always_comb begin
        tick  = !halt && !ps_restart && !clr_req && ((ps_q & ps_mask) == ps_mask);
        wrap0 = m0_wrap_en && (cnt_q == m0_val);
    end

    // Prescaler: restarts on any control write, runs while not halted
    always_ff @(posedge clk) begin
        if (!rst_n)                    ps_q <= '0;
        else if (clr_req || ps_restart) ps_q <= '0;
        else if (!halt)                 ps_q <= ps_q + 1'b1;
    end

    // Counter: clear, tick with optional wrap, or preset while halted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            step  <= 1'b0;
        end else begin
            step <= tick;
            if (clr_req)                 cnt_q <= '0;
            else if (tick)               cnt_q <= wrap0 ? '0 : cnt_q + 1'b1;
            else if (preset_we && halt)  cnt_q <= preset_val;
        end
    end

    assign count = cnt_q;

    assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !clr_req && !preset_we) |=> $stable(cnt_q));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap0) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    assert_m0_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wrap0) |=> (cnt_q == '0));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (cnt_q == '0) && !step);
endmodule

// File: rtl/frt_cmp_chan.sv
// One compare channel: a match value, a toggling pin and a sticky flag.
// A match is counted only on the cycle after the timebase stepped, so a
// halted or preset counter never toggles the pin. A flag set beats a
// clearing write that lands in the same cycle.
module frt_cmp_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             step,
    input  logic             val_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             flag_we,
    input  logic             flag_wbit,
    output logic [CNT_W-1:0] cmp_val,
    output logic             pin,
    output logic             flag
);
    logic match;

    // Match when the count has just stepped onto the compare value
    always_comb match = step && (count == cmp_val);

    // Compare value register
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_val <= '0;
        else if (val_we) cmp_val <= wdata;
    end

    // Output pin inverts on every match
    always_ff @(posedge clk) begin
        if (!rst_n)     pin <= 1'b0;
        else if (match) pin <= ~pin;
    end

    // Sticky flag: set on match, cleared by writing 0
    always_ff @(posedge clk) begin
        if (!rst_n)                      flag <= 1'b0;
        else if (match)                  flag <= 1'b1;
        else if (flag_we && !flag_wbit)  flag <= 1'b0;
    end

    assert_pin_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (pin != $past(pin)));

    assert_pin_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> $stable(pin));

    assert_flag_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag);
endmodule

// File: rtl/frt_cap_chan.sv
// One capture channel: a two-stage pin synchroniser, an edge detector
// controlled by the edge select, a capture register and a sticky flag.
// Assumes the pin holds each level for at least four clocks. A flag set
// beats a clearing write that lands in the same cycle.
module frt_cap_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic [1:0]       edge_sel,
    input  logic [CNT_W-1:0] count,
    input  logic             flag_we,
    input  logic             flag_wbit,
    output logic [CNT_W-1:0] cap_val,
    output logic             flag
);
    import frt_pkg::*;

    logic sync1, sync2, prev;
    logic rise, fall, evt;

    // Synchronise the pin and keep the previous level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
        end else begin
            sync1 <= pin_in;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    // Edge detection filtered by the selected edge kind
    always_comb begin
        rise = sync2 && !prev;
        fall = !sync2 && prev;
        evt  = (edge_sel[0] && rise) || (edge_sel[1] && fall);
    end

    // Capture register latches the count on a selected edge
    always_ff @(posedge clk) begin
        if (!rst_n)   cap_val <= '0;
        else if (evt) cap_val <= count;
    end

    // Sticky flag: set on capture, cleared by writing 0
    always_ff @(posedge clk) begin
        if (!rst_n)                     flag <= 1'b0;
        else if (evt)                   flag <= 1'b1;
        else if (flag_we && !flag_wbit) flag <= 1'b0;
    end

    assert_capture_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (cap_val == $past(count)));

    assert_capture_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel == EDGE_OFF) |=> $stable(cap_val));

    assert_capture_flag_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag);
endmodule

// File: rtl/frt_cc_top.sv
// Free-running timer top: register bus decode, control and enable
// registers, one timebase, the compare channels and the capture channels.
// Writes take effect on the clock edge where bus_wr is high. Read data is
// a combinational function of bus_addr.
module frt_cc_top #(
    parameter int N_CMP = 8,
    parameter int N_CAP = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [frt_pkg::ADR_W-1:0]   bus_addr,
    input  logic [frt_pkg::BUS_W-1:0]   bus_wdata,
    output logic [frt_pkg::BUS_W-1:0]   bus_rdata,
    input  logic [N_CAP-1:0]            cap_in,
    output logic [N_CMP-1:0]            cmp_out,
    output logic [N_CMP-1:0]            cmp_irq,
    output logic [N_CAP-1:0]            cap_irq
);
    import frt_pkg::*;

    localparam int EDGE_BITS = 2 * N_CAP;

    logic             halt_q, m0wrap_q;
    logic [SEL_W-1:0] ps_sel_q;
    logic [N_CMP-1:0] cmp_ie_q;
    logic [EDGE_BITS-1:0] cap_edge_q;
    logic [N_CAP-1:0] cap_ie_q;

    logic             wr_ctrl, wr_count, wr_cmp_flag, wr_cap_flag;
    logic             clr_req;
    logic [CNT_W-1:0] count;
    logic             step;

    logic [CNT_W-1:0] cmp_val [N_CMP];
    logic [N_CMP-1:0] cmp_flag;
    logic [CNT_W-1:0] cap_val [N_CAP];
    logic [N_CAP-1:0] cap_flag;

    // Write strobes for the shared registers
    always_comb begin
        wr_ctrl     = bus_wr && (int'(bus_addr) == ADR_CTRL);
        wr_count    = bus_wr && (int'(bus_addr) == ADR_COUNT);
        wr_cmp_flag = bus_wr && (int'(bus_addr) == ADR_CMP_FLAG);
        wr_cap_flag = bus_wr && (int'(bus_addr) == ADR_CAP_FLAG);
        clr_req     = wr_ctrl && bus_wdata[CTRL_ZERO];
    end

    // Control register: halt, period-from-channel-0, prescale select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q   <= 1'b0;
            m0wrap_q <= 1'b0;
            ps_sel_q <= '0;
        end else if (wr_ctrl) begin
            halt_q   <= bus_wdata[CTRL_HALT];
            m0wrap_q <= bus_wdata[CTRL_M0WRAP];
            ps_sel_q <= bus_wdata[CTRL_PS_LO +: SEL_W];
        end
    end

    // Interrupt enable and capture edge configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_ie_q   <= '0;
            cap_edge_q <= '0;
            cap_ie_q   <= '0;
        end else if (bus_wr) begin
            if (int'(bus_addr) == ADR_CMP_IE)  cmp_ie_q <= bus_wdata[N_CMP-1:0];
            if (int'(bus_addr) == ADR_CAP_CFG) begin
                cap_edge_q <= bus_wdata[EDGE_BITS-1:0];
                cap_ie_q   <= bus_wdata[CAP_IE_LO +: N_CAP];
            end
        end
    end

    frt_timebase #(.CNT_W(CNT_W), .SEL_W(SEL_W)) timebase_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt       (halt_q),
        .clr_req    (clr_req),
        .ps_restart (wr_ctrl),
        .ps_sel     (ps_sel_q),
        .preset_we  (wr_count),
        .preset_val (bus_wdata[CNT_W-1:0]),
        .m0_wrap_en (m0wrap_q),
        .m0_val     (cmp_val[0]),
        .count      (count),
        .step       (step)
    );

    for (genvar gi = 0; gi < N_CMP; gi++) begin : g_cmp
        frt_cmp_chan #(.CNT_W(CNT_W)) cmp_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .count     (count),
            .step      (step),
            .val_we    (bus_wr && (int'(bus_addr) == ADR_CMP_BASE + gi)),
            .wdata     (bus_wdata[CNT_W-1:0]),
            .flag_we   (wr_cmp_flag),
            .flag_wbit (bus_wdata[gi]),
            .cmp_val   (cmp_val[gi]),
            .pin       (cmp_out[gi]),
            .flag      (cmp_flag[gi])
        );
    end

    for (genvar gj = 0; gj < N_CAP; gj++) begin : g_cap
        frt_cap_chan #(.CNT_W(CNT_W)) cap_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_in    (cap_in[gj]),
            .edge_sel  (cap_edge_q[2*gj +: 2]),
            .count     (count),
            .flag_we   (wr_cap_flag),
            .flag_wbit (bus_wdata[gj]),
            .cap_val   (cap_val[gj]),
            .flag      (cap_flag[gj])
        );
    end

    // Interrupt lines gate each flag with its enable
    always_comb begin
        cmp_irq = cmp_flag & cmp_ie_q;
        cap_irq = cap_flag & cap_ie_q;
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            ADR_CTRL: begin
                bus_rdata[CTRL_HALT]             = halt_q;
                bus_rdata[CTRL_M0WRAP]           = m0wrap_q;
                bus_rdata[CTRL_PS_LO +: SEL_W]   = ps_sel_q;
            end
            ADR_COUNT:    bus_rdata[CNT_W-1:0] = count;
            ADR_CMP_IE:   bus_rdata[N_CMP-1:0] = cmp_ie_q;
            ADR_CMP_FLAG: bus_rdata[N_CMP-1:0] = cmp_flag;
            ADR_CAP_CFG: begin
                bus_rdata[EDGE_BITS-1:0]         = cap_edge_q;
                bus_rdata[CAP_IE_LO +: N_CAP]    = cap_ie_q;
            end
            ADR_CAP_FLAG: bus_rdata[N_CAP-1:0] = cap_flag;
            ADR_PINS:     bus_rdata[N_CMP-1:0] = cmp_out;
            default: begin
                for (int i = 0; i < N_CMP; i++)
                    if (int'(bus_addr) == ADR_CMP_BASE + i) bus_rdata[CNT_W-1:0] = cmp_val[i];
                for (int j = 0; j < N_CAP; j++)
                    if (int'(bus_addr) == ADR_CAP_BASE + j) bus_rdata[CNT_W-1:0] = cap_val[j];
            end
        endcase
    end

    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ie_q == '0) |-> (cap_irq == '0));
endmodule

// File: tb/frt_cc_top_tb_top.sv
// Self-checking bench: a capture vector table walked by one loop, then
// directed tests for reset, prescale, halt and preset, wrap, compare,
// period from channel 0 and the flag-set versus flag-clear collision.
module frt_cc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  cap_in = '0;
    logic [7:0]  cmp_out, cmp_irq;
    logic [3:0]  cap_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] exp_pins = '0;
    logic [15:0] rv;

    always #2.5 clk = ~clk;

    frt_cc_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
        .cmp_out(cmp_out), .cmp_irq(cmp_irq), .cap_irq(cap_irq)
    );

    // {edge_sel[1:0], start level, end level, capture expected, preset[15:0]}
    localparam int NV = 8;
    localparam logic [20:0] VEC [NV] = '{
        {2'b01, 1'b0, 1'b1, 1'b1, 16'h1234},
        {2'b01, 1'b1, 1'b0, 1'b0, 16'h2222},
        {2'b10, 1'b1, 1'b0, 1'b1, 16'hBEEF},
        {2'b10, 1'b0, 1'b1, 1'b0, 16'h3333},
        {2'b11, 1'b1, 1'b0, 1'b1, 16'h0001},
        {2'b11, 1'b0, 1'b1, 1'b1, 16'hFFFF},
        {2'b00, 1'b0, 1'b1, 1'b0, 16'h4444},
        {2'b01, 1'b0, 1'b0, 1'b0, 16'h5555}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = 5'(a);
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(0, rv); chk("R1 ctrl", rv, 0);
        rd(3, rv); chk("R1 cmp flags", rv, 0);
        rd(5, rv); chk("R1 cap flags", rv, 0);
        chk("R1 pins", cmp_out, 0);
        chk("R1 irqs", {cmp_irq, cap_irq}, 0);
        rd(1, rv); chk("R1 count runs from 0", (rv > 0 && rv < 16), 1);

        // Keep compare channels away from the ranges used below
        for (int i = 0; i < 8; i++) wr(8 + i, 16'h8000 + 16'(i));

        // R2/R4: clear and prescale by 8, first step 8 clocks after the write
        wr(0, 16'h0032);
        idle(11); rd(1, rv); chk("R2 count at 12 clocks /8", rv, 1);
        idle(23); rd(1, rv); chk("R2 count at 36 clocks /8", rv, 4);
        rd(0, rv); chk("R4 clear bit reads 0", rv, 16'h0030);

        // R3: halt and preset
        wr(0, 16'h0001);
        wr(1, 16'hABCD);
        rd(1, rv); chk("R3 preset while halted", rv, 16'hABCD);
        idle(6); rd(1, rv); chk("R3 halted count holds", rv, 16'hABCD);
        wr(0, 16'h0000);
        wr(1, 16'h1111);
        wr(0, 16'h0001);
        rd(1, rv); chk("R3 preset ignored while running", (rv >= 16'hABCD && rv < 16'hABDD), 1);

        // R10: wrap through 0xFFFF, compare value 0 matches
        wr(8 + 5, 16'h0000);
        wr(2, 16'h0020);
        wr(3, 16'h0000);
        wr(1, 16'hFFFE);
        wr(0, 16'h0000);
        idle(8);
        wr(0, 16'h0001);
        rd(1, rv); chk("R10 count wrapped", (rv >= 1 && rv < 16), 1);
        exp_pins[5] = ~exp_pins[5];
        chk("R10 pin5 toggled", cmp_out, exp_pins);
        chk("R10 irq5", cmp_irq, 8'h20);

        // R5: compare on channel 3, enable off so no interrupt
        wr(8 + 3, 16'h1000);
        wr(1, 16'h0FFE);
        wr(0, 16'h0000);
        idle(8);
        wr(0, 16'h0001);
        exp_pins[3] = ~exp_pins[3];
        chk("R5 pin3 toggled once", cmp_out, exp_pins);
        rd(3, rv); chk("R5 flags 3 and 5", rv, 16'h0028);
        chk("R5 irq gated by enable", cmp_irq, 8'h20);

        // R8: write 0 clears, write 1 keeps
        wr(3, 16'hFFF7);
        rd(3, rv); chk("R8 write 0 clears one flag", rv, 16'h0020);
        wr(3, 16'hFFFF);
        rd(3, rv); chk("R8 write 1 keeps flag", rv, 16'h0020);

        // Capture vector table (R7, R9)
        for (int i = 0; i < NV; i++) begin
            int ch = i % 4;
            wr(0, 16'h0001);
            wr(4, 16'h0000);
            cap_in[ch] = VEC[i][18];
            idle(5);
            wr(5, 16'h0000);
            wr(1, VEC[i][15:0]);
            wr(4, (16'(VEC[i][20:19]) << (2 * ch)) | (16'h0100 << ch));
            cap_in[ch] = VEC[i][17];
            idle(6);
            rd(5, rv); chk($sformatf("R7 vec%0d flag", i), rv, 16'(VEC[i][16]) << ch);
            chk($sformatf("R9 vec%0d irq", i), cap_irq, 4'(VEC[i][16]) << ch);
            if (VEC[i][16]) begin
                rd(16 + ch, rv); chk($sformatf("R7 vec%0d value", i), rv, VEC[i][15:0]);
            end
        end

        // R6: period defined by compare channel 0
        wr(0, 16'h0001);
        wr(3, 16'h0000);
        wr(8, 16'h0003);
        wr(0, 16'h0006);
        for (int k = 0; k < 5; k++) begin
            idle(3);
            rd(1, rv); chk("R6 count bounded by channel 0", (rv <= 3), 1);
        end
        rd(3, rv); chk("R6 channel 0 matched", rv[0], 1);
        wr(0, 16'h0001);

        // R8: capture edge and clearing write in the same cycle
        wr(4, 16'h0000);
        cap_in = '0;
        idle(5);
        wr(5, 16'h0000);
        wr(1, 16'h0042);
        wr(4, 16'h0101);
        @(negedge clk); cap_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 5'd5; bus_wdata = 16'h0000;
        @(negedge clk); bus_wr = 1'b0;
        rd(5, rv); chk("R8 set wins over clear", rv, 16'h0001);
        rd(16, rv); chk("R7 collision capture value", rv, 16'h0042);
        chk("R9 collision irq", cap_irq, 4'h1);
        wr(5, 16'h0000);
        rd(5, rv); chk("R8 later clear", rv, 16'h0000);
        chk("R9 irq drops", cap_irq, 4'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule